// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a register-programmed countdown timer that sits next to a local interrupt controller. Software loads a start value, picks a prescale ratio and a control word, and the timer counts down. When the count runs out, the block raises a one-cycle interrupt request that carries an 8-bit vector. A second way to arm it compares a free-running timestamp input against a programmed deadline.

The control word (vector, mask, mode) is acted on only at the moment the count runs out. Changing between one-shot and periodic therefore never disturbs a count in progress. A new prescale ratio takes hold on the count already running. Moving into or out of deadline mode wipes and disarms both the count and the deadline. Accepting, prioritising and delivering the request belong to the surrounding controller.

Register map, by word address: 0 start value (read/write), 1 running count (read-only), 2 prescale code (data bits 3, 1 and 0), 3 control word, 4 deadline.

Top module: `lvt_timer`

## Requirements
- R1: Writing address 0 outside deadline mode loads the written value into both the start register and the running count at that clock edge, whatever the other registers hold.
- R2: The running count drops by one every r clock cycles. The first drop comes r edges after the edge of the start-value write. r comes from the 3-bit code {data[3], data[1], data[0]} written to address 2: code 7 gives r = 1, and any other code c gives r = 2^(c+1), so 0 gives 2 and 2 gives 8.
- R3: When the count steps from 1 to 0 in one-shot mode (control bits 18:17 = 00), an unmasked timer drives irq_valid high for exactly the next cycle, with irq_vector equal to control bits 7:0. The count then stays at 0.
- R4: In periodic mode (control bits 18:17 = 01), the count reloads from the start register in the same edge that it would reach 0, so an unmasked timer with start value N interrupts every N*r cycles.
- R5: With the mask (control bit 16) set, an expiry raises no request, and periodic mode still reloads.
- R6: Writing 0 to address 0 stops the count at 0. No request follows until a nonzero value is written.
- R7: A control write that changes the mode between one-shot and periodic leaves the running count and its timing untouched. The mode, mask and vector in force at the expiry edge decide what happens.
- R8: A write to address 2 restarts the prescale phase at that edge and applies the new ratio to the count in progress. The decrement due at the write edge under the old ratio still happens.
- R9: A control write that enters or leaves deadline mode (control bits 18:17 = 10) sets the start register, the running count and the deadline to 0 at that edge.
- R10: In deadline mode, with a nonzero deadline D, the first edge at which the timestamp input is at least D causes one request in the next cycle (subject to the mask), and the deadline reads 0 afterwards. Writes to address 4 outside deadline mode are ignored.
- R11: In deadline mode, writes to address 0 are ignored, and addresses 0 and 1 read 0.
- R12: After reset, all registers read 0 except the control word, which reads 0x00010000 (masked, one-shot, vector 0). irq_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register word address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| tsc | input | 32 | Free-running timestamp |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with irq_valid |

## Verification
The embedded properties assume that writes arrive as single-cycle strobes, with addr and data stable around the edge. They also assume that the timestamp input only moves forward, so a deadline cannot be met and then un-met. The stimulus drives every write for exactly one cycle from the falling edge. It ties the timestamp to a cycle counter that increases monotonically. It places every mid-count control or prescale write on a known edge, so each expected request cycle can be worked out ahead of time as an exact number of edges.

// File: rtl/lvt_pkg.sv
// Package: shared types and helpers for the local interrupt timer.
// Assumes: mode field is 2 bits; prescale code is 3 bits.
package lvt_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } mode_e;

    localparam logic [2:0] ADR_START = 3'd0;
    localparam logic [2:0] ADR_COUNT = 3'd1;
    localparam logic [2:0] ADR_PRESC = 3'd2;
    localparam logic [2:0] ADR_CTRL  = 3'd3;
    localparam logic [2:0] ADR_DLINE = 3'd4;

    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_MODE_LSB = 17;

    // log2 of the prescale ratio: code 7 means divide by 1
    function automatic logic [2:0] presc_shift(input logic [2:0] code);
        return (code == 3'b111) ? 3'd0 : code + 3'd1;
    endfunction

endpackage

// File: rtl/lvt_prescaler.sv
// Prescaler: produces a one-cycle tick every 2^shift cycles.
// Assumes: restart pulses on any start-value or prescale write; the
// phase counter is PRE_W bits, enough for the largest ratio (2^PRE_W).
module lvt_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] code,
    output logic       tick
);
    import lvt_pkg::*;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] low_mask;

    // mask of the phase bits that must all be one for a tick
    assign low_mask = PRE_W'((32'd1 << presc_shift(code)) - 32'd1);
    assign tick     = ((phase_q & low_mask) == low_mask);

    // phase counter: cleared on restart, free-running otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
    end

    AST_DIV1_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b111) |-> tick); // R2

endmodule

// File: rtl/lvt_counter.sv
// Counter: the running count, with load, clear, tick-driven decrement
// and periodic reload. Flags the 1-to-0 step as an expiry.
// Assumes: clear has priority over load, load over decrement.
module lvt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic last_step;

    assign last_step = tick && (count == CNT_W'(1));
    assign expire    = last_step && !clear && !load;

    // running count update
    always_ff @(posedge clk) begin
        if (!rst_n || clear)               count <= '0;
        else if (load)                     count <= load_val;
        else if (last_step)                count <= periodic ? reload_val : '0;
        else if (tick && count != '0)      count <= count - 1'b1;
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (count == $past(load_val))); // R1
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> (count == '0)); // R6
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clear) |=> $stable(count)); // R2

endmodule

// File: rtl/lvt_deadline.sv
// Deadline comparator: holds the deadline and fires once when the
// timestamp reaches it. Assumes the timestamp is monotonic.
module lvt_deadline #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            armed_mode,
    input  logic            wr,
    input  logic [TS_W-1:0] wr_val,
    input  logic [TS_W-1:0] ts,
    output logic [TS_W-1:0] deadline,
    output logic            fire
);
    assign fire = armed_mode && (deadline != '0) && (ts >= deadline);

    // deadline register: clear, write, then self-clear on fire
    always_ff @(posedge clk) begin
        if (!rst_n || clear) deadline <= '0;
        else if (wr)         deadline <= wr_val;
        else if (fire)       deadline <= '0;
    end

    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr && !clear) |=> (deadline == '0)); // R10

endmodule

// File: rtl/lvt_timer.sv
// Top: register file, write decode and request generation for the
// local interrupt timer. Assumes single-cycle write strobes and a
// monotonic timestamp; CNT_W must be at least 19 to hold the control word.
module lvt_timer #(
    parameter int CNT_W = 32,
    parameter int TS_W  = 32,
    parameter int VEC_W = 8,
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic [TS_W-1:0]  tsc,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    import lvt_pkg::*;

    logic [CNT_W-1:0] start_q;
    logic [2:0]       presc_q;
    logic [VEC_W-1:0] vec_q;
    logic             mask_q;
    mode_e            mode_q;

    logic [CNT_W-1:0] count;
    logic [TS_W-1:0]  deadline;
    logic             tick, expire, fire;
    logic             in_dl, wr_start, wr_presc, wr_ctrl, wr_dl, dl_switch;
    mode_e            new_mode;
    logic [CNT_W-1:0] ctrl_rd;

    assign in_dl     = (mode_q == MODE_DEADLINE);
    assign new_mode  = mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
    assign wr_start  = wr_en && (addr == ADR_START) && !in_dl;
    assign wr_presc  = wr_en && (addr == ADR_PRESC);
    assign wr_ctrl   = wr_en && (addr == ADR_CTRL);
    assign wr_dl     = wr_en && (addr == ADR_DLINE) && in_dl;
    assign dl_switch = wr_ctrl && ((new_mode == MODE_DEADLINE) != in_dl);

    // software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            presc_q <= 3'b000;
            vec_q   <= '0;
            mask_q  <= 1'b1;
            mode_q  <= MODE_ONESHOT;
        end else begin
            if (dl_switch)     start_q <= '0;
            else if (wr_start) start_q <= wr_data;
            if (wr_presc) presc_q <= {wr_data[3], wr_data[1], wr_data[0]};
            if (wr_ctrl) begin
                vec_q  <= wr_data[VEC_W-1:0];
                mask_q <= wr_data[CTRL_MASK_BIT];
                mode_q <= new_mode;
            end
        end
    end

    lvt_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .restart(wr_start || wr_presc),
        .code(presc_q), .tick(tick)
    );

    lvt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(dl_switch), .load(wr_start),
        .load_val(wr_data), .reload_val(start_q),
        .periodic(mode_q == MODE_PERIODIC), .tick(tick),
        .count(count), .expire(expire)
    );

    lvt_deadline #(.TS_W(TS_W)) dl_i (
        .clk(clk), .rst_n(rst_n), .clear(dl_switch), .armed_mode(in_dl),
        .wr(wr_dl), .wr_val(TS_W'(wr_data)), .ts(tsc),
        .deadline(deadline), .fire(fire)
    );

    // request pulse: one cycle, vector captured at the expiry edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= ((expire && !in_dl) || fire) && !mask_q;
            irq_vector <= vec_q;
        end
    end

    // control word image for reads
    always_comb begin
        ctrl_rd                         = '0;
        ctrl_rd[VEC_W-1:0]              = vec_q;
        ctrl_rd[CTRL_MASK_BIT]          = mask_q;
        ctrl_rd[CTRL_MODE_LSB +: 2]     = mode_q;
    end

    // read mux
    always_comb begin
        case (addr)
            ADR_START: rd_data = start_q;
            ADR_COUNT: rd_data = count;
            ADR_PRESC: rd_data = CNT_W'({presc_q[2], 1'b0, presc_q[1:0]});
            ADR_CTRL:  rd_data = ctrl_rd;
            ADR_DLINE: rd_data = CNT_W'(deadline);
            default:   rd_data = '0;
        endcase
    end

    AST_SWITCH_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        dl_switch |=> (start_q == '0 && count == '0 && deadline == '0)); // R9
    AST_DL_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_dl |-> (count == '0)); // R11
    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !irq_valid); // R5

endmodule

// File: tb/lvt_timer_tb_top.sv
`timescale 1ns/1ps
module lvt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] tsc;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int    exp_cyc[$];
    int    exp_vec[$];
    string exp_tag[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tsc = 32'(cyc);

    lvt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tsc(tsc),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic push(input int c, input int v, input string tag);
        exp_cyc.push_back(c); exp_vec.push_back(v); exp_tag.push_back(tag);
    endtask

    // caller stands just after a falling edge; returns the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        e = cyc; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: compares each request against the expected queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                checks++; errors++;
                $display("FAIL %s: actual no request expected request at cycle %0d",
                         exp_tag[0], exp_cyc[0]);
                void'(exp_cyc.pop_front()); void'(exp_vec.pop_front()); void'(exp_tag.pop_front());
            end
            if (irq_valid) begin
                checks++;
                if (exp_cyc.size() == 0) begin
                    errors++;
                    $display("FAIL R3/R5/R6: actual request at cycle %0d vector 0x%02h expected none",
                             cyc, irq_vector);
                end else begin
                    if (exp_cyc[0] != cyc || exp_vec[0] != int'(irq_vector)) begin
                        errors++;
                        $display("FAIL %s: actual cycle %0d vector 0x%02h expected cycle %0d vector 0x%02h",
                                 exp_tag[0], cyc, irq_vector, exp_cyc[0], exp_vec[0]);
                    end
                    void'(exp_cyc.pop_front()); void'(exp_vec.pop_front()); void'(exp_tag.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, w2, e, dl;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(3'd0, v); chk("R12 start", v, 32'h0);
        rd(3'd1, v); chk("R12 count", v, 32'h0);
        rd(3'd3, v); chk("R12 ctrl", v, 32'h0001_0000);
        chk("R12 irq", {31'b0, irq_valid}, 32'h0);

        // R2 divide by 8 (code 010), one-shot vector 0x21
        wr(3'd3, 32'h0000_0021, e);
        wr(3'd2, 32'h0000_0002, e);
        wr(3'd0, 32'd3, w);
        push(w + 24, 8'h21, "R2 div8");
        wait_to(w + 30);

        // R1/R3 divide by 1, one-shot
        wr(3'd2, 32'h0000_000B, e);
        wr(3'd0, 32'd5, w);
        rd(3'd1, v); chk("R1 load", v, 32'd5);
        push(w + 5, 8'h21, "R3 oneshot");
        wait_to(w + 20);
        rd(3'd1, v); chk("R3 stays zero", v, 32'd0);

        // R4/R7 periodic, switched to one-shot mid-count
        wr(3'd3, 32'h0002_0030, e);
        wr(3'd0, 32'd4, w);
        push(w + 4, 8'h30, "R4 period1");
        push(w + 8, 8'h30, "R4 period2");
        push(w + 12, 8'h30, "R4 period3");
        wait_to(w + 13);
        wr(3'd3, 32'h0000_0031, e);
        push(w + 16, 8'h31, "R7 to oneshot");
        wait_to(w + 30);

        // R7/R6 one-shot switched to periodic, then disarmed by zero
        wr(3'd3, 32'h0000_0032, e);
        wr(3'd0, 32'd6, w);
        push(w + 6, 8'h32, "R7 to periodic a");
        wait_to(w + 2);
        wr(3'd3, 32'h0002_0032, e);
        push(w + 12, 8'h32, "R7 to periodic b");
        wait_to(w + 13);
        wr(3'd0, 32'd0, e);
        wait_to(w + 30);
        rd(3'd1, v); chk("R6 disarmed", v, 32'd0);

        // R5 masked periodic still reloads
        wr(3'd3, 32'h0003_0050, e);
        wr(3'd0, 32'd3, w);
        wait_to(w + 3);
        rd(3'd1, v); chk("R5 reload", v, 32'd3);
        wait_to(w + 4);
        rd(3'd1, v); chk("R5 after reload", v, 32'd2);
        wr(3'd0, 32'd0, w2);
        wr(3'd3, 32'h0002_0051, e);
        wait_to(e + 15);
        rd(3'd1, v); chk("R6 zero stops", v, 32'd0);

        // R8 divide change mid-count
        wr(3'd3, 32'h0000_0060, e);
        wr(3'd0, 32'd10, w);
        wait_to(w + 3);
        wr(3'd2, 32'h0000_0000, e);
        push(w + 16, 8'h60, "R8 new ratio");
        wait_to(w + 25);
        wr(3'd2, 32'h0000_000B, e);

        // R9/R11/R10 deadline mode
        wr(3'd0, 32'd1000, w);
        wr(3'd3, 32'h0004_0040, e);
        rd(3'd0, v); chk("R9 start wiped", v, 32'd0);
        rd(3'd1, v); chk("R9 count wiped", v, 32'd0);
        wr(3'd0, 32'd50, e);
        rd(3'd0, v); chk("R11 start ignored", v, 32'd0);
        rd(3'd1, v); chk("R11 count zero", v, 32'd0);
        dl = cyc + 21;
        push(dl + 1, 8'h40, "R10 deadline");
        wr(3'd4, 32'(dl), e);
        wait_to(dl + 2);
        rd(3'd4, v); chk("R10 cleared", v, 32'd0);
        push(cyc + 2, 8'h40, "R10 past deadline");
        wr(3'd4, 32'd5, e);
        wait_to(e + 5);
        dl = cyc + 1000;
        wr(3'd4, 32'(dl), e);
        rd(3'd4, v); chk("R10 armed", v, 32'(dl));
        wr(3'd3, 32'h0000_0070, e);
        rd(3'd4, v); chk("R9 deadline wiped", v, 32'd0);
        wr(3'd4, 32'd7, e);
        rd(3'd4, v); chk("R10 write outside mode", v, 32'd0);
        wait_to(e + 20);

        // any expected request never seen
        while (exp_cyc.size() > 0) begin
            checks++; errors++;
            $display("FAIL %s: actual no request expected request at cycle %0d",
                     exp_tag[0], exp_cyc[0]);
            void'(exp_cyc.pop_front()); void'(exp_vec.pop_front()); void'(exp_tag.pop_front());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule